// File: doc/BRIEF.md
# Address Translation Window Table

This block holds a small programmable table of address translation windows for the path where AXI requests are turned into PCIe requests. Every entry describes one naturally aligned, power-of-two sized source region, the base address that region moves to, and a 32-bit attribute word. Part of that word names the kind of transaction the target expects (memory, I/O or configuration), and one bit marks an entry meant for the inbound direction.

Software fills the table through a 32-bit register port. Each entry takes a 0x20-byte slot holding five word registers. A downstream request engine presents a 64-bit address on the lookup port. One cycle later it receives a hit flag, the translated address, the attribute word of the winning entry, a decoded target kind and the inbound flag. When no entry matches, the address comes back unchanged and the hit flag stays low.

Top module: `xlat_window_table`

## Requirements
- R1: Entry i occupies register addresses i*0x20 to i*0x20+0x13. Offset 0x00 is the low source word: bit 0 is the enable, bits 6:1 are the size exponent W, and bits 31:12 are source address bits 31:12. Offset 0x04 holds source bits 63:32. Offset 0x08 holds translated base bits 31:12 in its bits 31:12. Offset 0x0C holds translated bits 63:32. Offset 0x10 is the 32-bit attribute word. A read returns the addressed word on reg_rdata in the cycle after reg_rd is sampled.
- R2: Bits 11:7 of the low source word and bits 11:0 of the low translated word are not stored and read back as zero. Writes to any other offset, or to a slot at or beyond the entry count, change nothing, and such reads return zero.
- R3: After reset every entry is disabled and all of its registers read zero. Every lookup misses until software programs an entry. After reset the lookup outputs are vld=0, hit=0, address 0, attribute 0 and kind 3.
- R4: An entry of size exponent W covers 2^(W+1) bytes. An address hits the entry when the entry is enabled and the address equals the source base in every bit at or above bit W+1.
- R5: On a hit, the output address takes bits 63:W+1 from the translated base and bits W:0 from the input address.
- R6: When several entries hit, the entry with the lowest index supplies the address and the attribute word.
- R7: On a miss, hit is 0, the output address equals the input address, the attribute word is 0 and the kind is 3.
- R8: On a hit, the attribute word of the winning entry is output. The kind is decoded from attribute bits 21:0: 0x000000 gives 0 (memory), 0x020000 gives 1 (I/O), 0x000001 gives 2 (configuration), and any other value gives 3. The inbound flag equals attribute bit 22.
- R9: lk_vld rises in the cycle after lk_req is sampled, together with the results of that lookup. In cycles without a request, all result outputs hold their values.
- R10: A register write affects lookups sampled in later cycles only. A lookup sampled on the same edge as a write uses the table as it was before that write.
- R11: Clearing bit 0 of an entry removes it from matching even though its other fields stay in place. W=63 makes an entry cover the whole 64-bit space, so the output address equals the input address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | REG_AW | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after reg_rd |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | 64 | Address to translate |
| lk_vld | output | 1 | Lookup results valid |
| lk_hit | output | 1 | Some entry matched |
| lk_xaddr | output | 64 | Translated or passed-through address |
| lk_param | output | 32 | Attribute word of the winning entry, 0 on miss |
| lk_kind | output | 2 | Decoded target kind |
| lk_inbound | output | 1 | Winning entry is marked inbound |

## Verification
Register read data and all lookup results are each due exactly one clock edge after the strobe that asks for them. The bench drives every strobe for a single cycle starting at a falling edge. It reads the results at the next falling edge, which is half a period after the edge that loaded them. The same-cycle test places a write and a lookup on one edge and expects the lookup to report the table from before the write. Only the following lookup may show the change. The idle test waits several cycles after a lookup and expects lk_vld low while the results keep their last values.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  localparam int ENTRY_SHIFT = 5;  // 0x20-byte slot per entry

  localparam logic [4:0] OFS_SRC_LO = 5'h00;
  localparam logic [4:0] OFS_SRC_HI = 5'h04;
  localparam logic [4:0] OFS_DST_LO = 5'h08;
  localparam logic [4:0] OFS_DST_HI = 5'h0C;
  localparam logic [4:0] OFS_PARAM  = 5'h10;

  localparam logic [21:0] ID_MEM = 22'h000000;
  localparam logic [21:0] ID_IO  = 22'h020000;
  localparam logic [21:0] ID_CFG = 22'h000001;
  localparam int INBOUND_BIT = 22;

  typedef enum logic [1:0] {
    KIND_MEM   = 2'd0,
    KIND_IO    = 2'd1,
    KIND_CFG   = 2'd2,
    KIND_OTHER = 2'd3
  } xlat_kind_e;

  typedef struct packed {
    logic        en;
    logic [5:0]  wexp;
    logic [63:12] src;
    logic [63:12] dst;
    logic [31:0] param;
  } xlat_entry_t;

  // Ones in every bit below W+1; all ones for W=63.
  function automatic logic [63:0] span_mask(input logic [5:0] wexp);
    logic [6:0] sh;
    sh = {1'b0, wexp} + 7'd1;
    return ~({64{1'b1}} << sh);
  endfunction

  function automatic logic [31:0] entry_word(input xlat_entry_t e, input logic [4:0] ofs);
    logic [31:0] w;
    case (ofs)
      OFS_SRC_LO: w = {e.src[31:12], 5'b0, e.wexp, e.en};
      OFS_SRC_HI: w = e.src[63:32];
      OFS_DST_LO: w = {e.dst[31:12], 12'b0};
      OFS_DST_HI: w = e.dst[63:32];
      OFS_PARAM:  w = e.param;
      default:    w = '0;
    endcase
    return w;
  endfunction

  function automatic xlat_kind_e decode_kind(input logic [31:0] p);
    xlat_kind_e k;
    case (p[21:0])
      ID_MEM:  k = KIND_MEM;
      ID_IO:   k = KIND_IO;
      ID_CFG:  k = KIND_CFG;
      default: k = KIND_OTHER;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/xlat_regfile.sv
module xlat_regfile
  import xlat_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int REG_AW      = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          reg_wr,
  input  logic                          reg_rd,
  input  logic [REG_AW-1:0]             reg_addr,
  input  logic [31:0]                   reg_wdata,
  output logic [31:0]                   reg_rdata,
  output xlat_entry_t [NUM_ENTRIES-1:0] tbl
);

  localparam int IDX_W = REG_AW - ENTRY_SHIFT;

  logic [IDX_W-1:0]                   idx;
  logic [ENTRY_SHIFT-1:0]             ofs;
  logic [NUM_ENTRIES-1:0][31:0]       rd_word;
  logic [31:0]                        rd_any;

  assign idx = reg_addr[REG_AW-1:ENTRY_SHIFT];
  assign ofs = reg_addr[ENTRY_SHIFT-1:0];

  generate
    for (genvar gi = 0; gi < NUM_ENTRIES; gi++) begin : g_ent
      xlat_entry_t ent_q;
      logic        sel;

      assign sel = (idx == IDX_W'(gi));

      always_ff @(posedge clk) begin
        if (rst) begin
          ent_q <= '0;
        end else if (reg_wr && sel) begin
          case (ofs)
            OFS_SRC_LO: begin
              ent_q.en         <= reg_wdata[0];
              ent_q.wexp       <= reg_wdata[6:1];
              ent_q.src[31:12] <= reg_wdata[31:12];
            end
            OFS_SRC_HI: ent_q.src[63:32] <= reg_wdata;
            OFS_DST_LO: ent_q.dst[31:12] <= reg_wdata[31:12];
            OFS_DST_HI: ent_q.dst[63:32] <= reg_wdata;
            OFS_PARAM:  ent_q.param      <= reg_wdata;
            default: ;
          endcase
        end
      end

      assign rd_word[gi] = sel ? entry_word(ent_q, ofs) : 32'h0;
      assign tbl[gi]     = ent_q;
    end
  endgenerate

  always_comb begin
    rd_any = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) rd_any = rd_any | rd_word[i];
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_any;
  end

endmodule

// File: rtl/xlat_entry_match.sv
module xlat_entry_match
  import xlat_pkg::*;
(
  input  xlat_entry_t ent,
  input  logic [63:0] addr,
  output logic        hit,
  output logic [63:0] xaddr
);

  logic [63:0] low;
  logic [63:0] src_base;
  logic [63:0] dst_base;

  assign low      = span_mask(ent.wexp);
  assign src_base = {ent.src, 12'h000};
  assign dst_base = {ent.dst, 12'h000};

  assign hit   = ent.en && (((addr ^ src_base) & ~low) == 64'h0);
  assign xaddr = (dst_base & ~low) | (addr & low);

endmodule

// File: rtl/xlat_pick.sv
module xlat_pick
  import xlat_pkg::*;
#(
  parameter int NUM_ENTRIES = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          lk_req,
  input  logic [63:0]                   lk_addr,
  input  logic [NUM_ENTRIES-1:0]        hit_vec,
  input  logic [NUM_ENTRIES-1:0][63:0]  xaddr_vec,
  input  xlat_entry_t [NUM_ENTRIES-1:0] tbl,
  output logic                          vld_q,
  output logic                          hit_q,
  output logic [63:0]                   xaddr_q,
  output logic [31:0]                   param_q,
  output xlat_kind_e                    kind_q,
  output logic                          inb_q
);

  logic        win_hit;
  logic [63:0] win_addr;
  logic [31:0] win_param;
  xlat_kind_e  win_kind;
  logic        win_inb;

  // Scan from the top so the lowest index is the last to overwrite.
  always_comb begin
    win_hit   = 1'b0;
    win_addr  = lk_addr;
    win_param = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        win_hit   = 1'b1;
        win_addr  = xaddr_vec[i];
        win_param = tbl[i].param;
      end
    end
    win_kind = win_hit ? decode_kind(win_param) : KIND_OTHER;
    win_inb  = win_hit & win_param[INBOUND_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q   <= 1'b0;
      hit_q   <= 1'b0;
      xaddr_q <= '0;
      param_q <= '0;
      kind_q  <= KIND_OTHER;
      inb_q   <= 1'b0;
    end else begin
      vld_q <= lk_req;
      if (lk_req) begin
        hit_q   <= win_hit;
        xaddr_q <= win_addr;
        param_q <= win_param;
        kind_q  <= win_kind;
        inb_q   <= win_inb;
      end
    end
  end

endmodule

// File: rtl/xlat_window_table.sv
module xlat_window_table
  import xlat_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int REG_AW      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              lk_req,
  input  logic [63:0]       lk_addr,
  output logic              lk_vld,
  output logic              lk_hit,
  output logic [63:0]       lk_xaddr,
  output logic [31:0]       lk_param,
  output logic [1:0]        lk_kind,
  output logic              lk_inbound
);

  xlat_entry_t [NUM_ENTRIES-1:0] tbl;
  logic [NUM_ENTRIES-1:0]        hit_vec;
  logic [NUM_ENTRIES-1:0][63:0]  xaddr_vec;
  xlat_kind_e                    kind_q;

  xlat_regfile #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .REG_AW     (REG_AW)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .tbl      (tbl)
  );

  generate
    for (genvar gm = 0; gm < NUM_ENTRIES; gm++) begin : g_match
      xlat_entry_match u_match (
        .ent  (tbl[gm]),
        .addr (lk_addr),
        .hit  (hit_vec[gm]),
        .xaddr(xaddr_vec[gm])
      );
    end
  endgenerate

  xlat_pick #(
    .NUM_ENTRIES(NUM_ENTRIES)
  ) u_pick (
    .clk      (clk),
    .rst      (rst),
    .lk_req   (lk_req),
    .lk_addr  (lk_addr),
    .hit_vec  (hit_vec),
    .xaddr_vec(xaddr_vec),
    .tbl      (tbl),
    .vld_q    (lk_vld),
    .hit_q    (lk_hit),
    .xaddr_q  (lk_xaddr),
    .param_q  (lk_param),
    .kind_q   (kind_q),
    .inb_q    (lk_inbound)
  );

  assign lk_kind = kind_q;

endmodule

// File: rtl/xlat_window_table_chk.sv
module xlat_window_table_chk #(
  parameter int REG_AW = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic              lk_req,
  input logic [63:0]       lk_addr,
  input logic              lk_vld,
  input logic              lk_hit,
  input logic [63:0]       lk_xaddr,
  input logic [31:0]       lk_param,
  input logic [1:0]        lk_kind,
  input logic              lk_inbound
);

  logic armed;
  logic wr_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b0;
      wr_seen <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (reg_wr) wr_seen <= 1'b1;
    end
  end

  assert_vld_tracks_req_R9: assert property (@(posedge clk) disable iff (rst)
    armed |-> (lk_vld == $past(lk_req)));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(lk_req)) |->
      ($stable(lk_hit) && $stable(lk_xaddr) && $stable(lk_param) &&
       $stable(lk_kind) && $stable(lk_inbound)));

  assert_miss_passthrough_R7: assert property (@(posedge clk) disable iff (rst)
    (armed && lk_vld && !lk_hit) |->
      (lk_xaddr == $past(lk_addr) && lk_param == 32'h0 &&
       lk_kind == 2'd3 && !lk_inbound));

  assert_io_kind_id_R8: assert property (@(posedge clk) disable iff (rst)
    (lk_vld && lk_hit && lk_kind == 2'd1) |-> (lk_param[21:0] == 22'h020000));

  assert_no_hit_unprogrammed_R3: assert property (@(posedge clk) disable iff (rst)
    (lk_vld && !wr_seen) |-> !lk_hit);

endmodule

bind xlat_window_table xlat_window_table_chk #(.REG_AW(REG_AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .lk_req    (lk_req),
  .lk_addr   (lk_addr),
  .lk_vld    (lk_vld),
  .lk_hit    (lk_hit),
  .lk_xaddr  (lk_xaddr),
  .lk_param  (lk_param),
  .lk_kind   (lk_kind),
  .lk_inbound(lk_inbound)
);

// File: tb/xlat_window_table_bench.sv
module xlat_window_table_bench;

  localparam int CLK_PERIOD = 10;
  localparam int REG_AW     = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reg_wr = 1'b0;
  logic              reg_rd = 1'b0;
  logic [REG_AW-1:0] reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic              lk_req = 1'b0;
  logic [63:0]       lk_addr = '0;
  logic              lk_vld;
  logic              lk_hit;
  logic [63:0]       lk_xaddr;
  logic [31:0]       lk_param;
  logic [1:0]        lk_kind;
  logic              lk_inbound;

  int checks   = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_window_table #(.NUM_ENTRIES(4), .REG_AW(REG_AW)) u_xlat_window_table (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lk_req(lk_req), .lk_addr(lk_addr), .lk_vld(lk_vld), .lk_hit(lk_hit),
    .lk_xaddr(lk_xaddr), .lk_param(lk_param), .lk_kind(lk_kind),
    .lk_inbound(lk_inbound)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [REG_AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [REG_AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic look(input logic [63:0] a);
    @(negedge clk);
    lk_req = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_req = 1'b0;
  endtask

  task automatic chk_look(input string tag, input logic hit, input logic [63:0] xa,
                          input logic [31:0] prm, input logic [1:0] kind, input logic inb);
    chk({tag, " vld"}, 64'(lk_vld), 64'd1);
    chk({tag, " hit"}, 64'(lk_hit), 64'(hit));
    chk({tag, " xaddr"}, lk_xaddr, xa);
    chk({tag, " param"}, 64'(lk_param), 64'(prm));
    chk({tag, " kind"}, 64'(lk_kind), 64'(kind));
    chk({tag, " inbound"}, 64'(lk_inbound), 64'(inb));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R3 vld after reset", 64'(lk_vld), 64'd0);
    chk("R3 kind after reset", 64'(lk_kind), 64'd3);
    for (int o = 0; o < 5; o++) begin
      rd(REG_AW'(o * 4), d);
      chk("R3 entry0 reg zero", 64'(d), 64'd0);
    end
    look(64'h0000_0000_0000_1234);
    chk_look("R3 R7 miss after reset", 1'b0, 64'h0000_0000_0000_1234, 32'h0, 2'd3, 1'b0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h24, 32'hDEAD_BEEF);
    wr(8'h28, 32'hFFFF_FFFF);
    wr(8'h30, 32'h00AB_CDEF);
    wr(8'h34, 32'h1234_5678);      // unused offset
    wr(8'h80, 32'hFFFF_FFFF);      // slot beyond entry count
    rd(8'h20, d); chk("R1 R2 src lo readback", 64'(d), 64'hFFFF_F07F);
    rd(8'h24, d); chk("R1 src hi readback", 64'(d), 64'hDEAD_BEEF);
    rd(8'h28, d); chk("R2 dst lo low bits zero", 64'(d), 64'hFFFF_F000);
    rd(8'h2C, d); chk("R1 dst hi untouched", 64'(d), 64'h0);
    rd(8'h30, d); chk("R1 param readback", 64'(d), 64'h00AB_CDEF);
    rd(8'h34, d); chk("R2 unused offset reads zero", 64'(d), 64'h0);
    rd(8'h80, d); chk("R2 out of range slot", 64'(d), 64'h0);
    rd(8'h00, d); chk("R2 entry0 unaffected", 64'(d), 64'h0);
    wr(8'h20, 32'h0000_0000);      // disable entry 1 again
  endtask

  task automatic t_hit_basic();
    wr(8'h00, 32'h0000_003B);      // enable, W=29: 1 GiB
    wr(8'h04, 32'h0000_0009);
    wr(8'h08, 32'h4000_0000);
    wr(8'h0C, 32'h0000_0012);
    wr(8'h10, 32'h0000_0000);
    look(64'h0000_0009_1234_5678);
    chk_look("R4 R5 R8 inside window", 1'b1, 64'h0000_0012_5234_5678, 32'h0, 2'd0, 1'b0);
    look(64'h0000_0009_3FFF_FFFF);
    chk_look("R4 R5 top byte", 1'b1, 64'h0000_0012_7FFF_FFFF, 32'h0, 2'd0, 1'b0);
    look(64'h0000_0009_4000_0000);
    chk_look("R4 R7 above window", 1'b0, 64'h0000_0009_4000_0000, 32'h0, 2'd3, 1'b0);
    look(64'h0000_0008_FFFF_FFFF);
    chk_look("R4 R7 below window", 1'b0, 64'h0000_0008_FFFF_FFFF, 32'h0, 2'd3, 1'b0);
  endtask

  task automatic t_small_window();
    wr(8'h40, 32'h3000_5017);      // enable, W=11: 4 KiB
    wr(8'h44, 32'h0000_0000);
    wr(8'h48, 32'h0000_A000);
    wr(8'h4C, 32'h0000_0001);
    wr(8'h50, 32'h0002_0000);      // I/O id
    look(64'h0000_0000_3000_5ABC);
    chk_look("R5 R8 io 4KiB", 1'b1, 64'h0000_0001_0000_AABC, 32'h0002_0000, 2'd1, 1'b0);
    look(64'h0000_0000_3000_6000);
    chk_look("R4 next page misses", 1'b0, 64'h0000_0000_3000_6000, 32'h0, 2'd3, 1'b0);
  endtask

  task automatic t_priority();
    wr(8'h60, 32'h0000_003F);      // enable, W=31: 4 GiB
    wr(8'h64, 32'h0000_0009);
    wr(8'h68, 32'h0000_0000);
    wr(8'h6C, 32'h0000_0020);
    wr(8'h70, 32'h0000_0001);      // configuration id
    look(64'h0000_0009_1000_0000);
    chk_look("R6 lowest index wins", 1'b1, 64'h0000_0012_5000_0000, 32'h0, 2'd0, 1'b0);
    look(64'h0000_0009_8000_0004);
    chk_look("R6 R8 only entry3", 1'b1, 64'h0000_0020_8000_0004, 32'h1, 2'd2, 1'b0);
    wr(8'h00, 32'h0000_003A);      // clear enable of entry 0
    look(64'h0000_0009_1000_0000);
    chk_look("R11 disabled entry skipped", 1'b1, 64'h0000_0020_1000_0000, 32'h1, 2'd2, 1'b0);
  endtask

  task automatic t_inbound();
    wr(8'h50, 32'h004E_0004);
    look(64'h0000_0000_3000_5004);
    chk_look("R8 inbound flag", 1'b1, 64'h0000_0001_0000_A004, 32'h004E_0004, 2'd3, 1'b1);
  endtask

  task automatic t_hold();
    logic [63:0] xa;
    xa = lk_xaddr;
    repeat (3) @(negedge clk);
    chk("R9 vld low when idle", 64'(lk_vld), 64'd0);
    chk("R9 xaddr held", lk_xaddr, xa);
    chk("R9 hit held", 64'(lk_hit), 64'd1);
    chk("R9 param held", 64'(lk_param), 64'h004E_0004);
  endtask

  task automatic t_whole();
    wr(8'h20, 32'h0000_007F);      // entry 1: enable, W=63
    look(64'hABCD_0000_1234_5678);
    chk_look("R11 whole space", 1'b1, 64'hABCD_0000_1234_5678, 32'h00AB_CDEF, 2'd3, 1'b0);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h20; reg_wdata = 32'h0;
    lk_req = 1'b1; lk_addr = 64'h5;
    @(negedge clk);
    reg_wr = 1'b0; lk_req = 1'b0;
    chk_look("R10 same edge sees old table", 1'b1, 64'h5, 32'h00AB_CDEF, 2'd3, 1'b0);
    look(64'h5);
    chk_look("R10 next lookup sees write", 1'b0, 64'h5, 32'h0, 2'd3, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_hit_basic();
    t_small_window();
    t_priority();
    t_inbound();
    t_hold();
    t_whole();
    t_same_cycle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule